// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This peripheral holds two independent counters behind a small word-addressed register port. Each channel has a control word, a load word and a live count word. A channel in generate mode counts up or down. When it reaches its terminal value it raises its status flag and pulses its event output, and it can optionally reload from its load word. A channel in capture mode watches a synchronised external input. On each rising edge it copies the running count into its load word.

To measure a fixed interval, software can preload a channel near its terminal value, for example all-ones minus an offset in up mode. The counter then rolls over after the chosen number of clocks. When the pairing bit in channel 0 is set, the two channels form a PWM generator. Channel 0 fixes the period and channel 1 fixes the high time, and a single output pin carries the waveform.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register reads zero, and the interrupt, event and PWM outputs are low.
- R2: Address bit 2 selects the channel. Address bits 1:0 select the control word (0), the load word (1) or the count word (2). Code 3 reads zero. A write to one channel leaves the other channel's registers unchanged.
- R3: Control bit 3 (load-now) copies the load word into the count on the clock edge after the write and then clears itself. Counting (bit 0, run) resumes on the following edge.
- R4: With bit 1 (down) and bit 2 (auto-reload) set, the count steps down to zero. On the edge where it is zero it reloads, so the period is load+1 clocks.
- R5: With bit 1 clear the count steps up. Without auto-reload it wraps from all-ones to zero and sets flag bit 7.
- R6: In generate mode (bit 5 clear), each expiry sets flag bit 7 and drives the channel's event output high for exactly the next clock. The interrupt output equals the flag ANDed with bit 4 (interrupt enable).
- R7: Writing 1 to bit 7 clears the flag. If an expiry falls in the same cycle as the clear, the flag stays set.
- R8: With bit 5 set, a rising edge on the channel's capture input loads the count into the load word and sets the flag. This happens on the third clock edge after the input rises, because two synchroniser stages and an edge stage sit in the path.
- R9: If a capture and a bus write to the same load word fall on one edge, the captured count wins.
- R10: Bus writes to a count word are ignored.
- R11: With bit 6 (pair) set in channel 0, and both channels counting down, channel 0 with auto-reload and load P sets the period to P+1 clocks. Channel 1 with load H is restarted at each channel 0 expiry, and the PWM output is high for H+1 clocks per period. With pair clear the output is low.
- R12: When H is greater than or equal to P, the PWM output stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address: channel in bit 2, register in bits 1:0 |
| we | input | 1 | Write strobe |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for the addressed register (combinational) |
| cap_in | input | 2 | Asynchronous capture event per channel |
| irq | output | 2 | Interrupt request per channel |
| ev_out | output | 2 | One-clock pulse per generate-mode expiry |
| pwm_out | output | 1 | Paired PWM waveform |

## Verification
The flag of a channel can be set by an expiry and cleared by a software write on the same edge. The bench counts edges from a load-now write and places the clearing write exactly on the second reload of a six-clock period. It expects the flag to survive, and expects a clearing write one edge later to remove it. The load word has the same kind of conflict between a capture and a bus write. The bench raises the capture input three edges before a bus write to that word and expects the captured count to be read back, not the written value.

// File: rtl/dual_interval_timer.sv
module dual_interval_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [1:0]    cap_in,
  output logic [1:0]    irq,
  output logic [1:0]    ev_out,
  output logic          pwm_out
);
  localparam int NCH = 2;
  localparam int CB = 8;
  localparam int B_RUN = 0, B_DOWN = 1, B_RELOAD = 2, B_LDNOW = 3;
  localparam int B_IE = 4, B_CAP = 5, B_PAIR = 6, B_FLAG = CB - 1;
  localparam logic [1:0] A_CTL = 2'd0, A_LD = 2'd1, A_CNT = 2'd2;

  logic [NCH-1:0][CB-1:0] ctl_v;
  logic [NCH-1:0][CW-1:0] cnt_v, ld_v;
  logic [NCH-1:0]         expire, capt;
  logic                   pair;

  assign pair = ctl_v[0][B_PAIR];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CB-1:0] ctl;
    logic [CW-1:0] cnt, ld;
    logic [2:0]    sync;
    logic          ev_q, sel, wr_ctl, wr_ld, active, hit, restart;

    assign sel    = we && (addr[2] == 1'(c));
    assign wr_ctl = sel && (addr[1:0] == A_CTL);
    assign wr_ld  = sel && (addr[1:0] == A_LD);
    assign active = ctl[B_RUN] && !ctl[B_LDNOW];
    assign hit    = ctl[B_DOWN] ? (cnt == '0) : (&cnt);
    assign expire[c] = active && hit && !ctl[B_CAP];
    assign capt[c]   = ctl[B_CAP] && sync[1] && !sync[2];

    if (c == 1) begin : g_follow
      assign restart = pair && expire[0];
    end else begin : g_lead
      assign restart = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl  <= '0;
        cnt  <= '0;
        ld   <= '0;
        sync <= '0;
        ev_q <= 1'b0;
      end else begin
        sync <= {sync[1:0], cap_in[c]};
        ev_q <= expire[c];

        if (wr_ctl)
          ctl[CB-2:0] <= wdata[CB-2:0];
        else if (ctl[B_LDNOW])
          ctl[B_LDNOW] <= 1'b0;

        if (expire[c] || capt[c])
          ctl[B_FLAG] <= 1'b1;
        else if (wr_ctl && wdata[B_FLAG])
          ctl[B_FLAG] <= 1'b0;

        if (capt[c])
          ld <= cnt;
        else if (wr_ld)
          ld <= wdata;

        if (ctl[B_LDNOW] || restart)
          cnt <= ld;
        else if (active) begin
          if (expire[c] && ctl[B_RELOAD])
            cnt <= ld;
          else if (ctl[B_DOWN])
            cnt <= cnt - 1'b1;
          else
            cnt <= cnt + 1'b1;
        end
      end
    end

    assign ctl_v[c]  = ctl;
    assign cnt_v[c]  = cnt;
    assign ld_v[c]   = ld;
    assign irq[c]    = ctl[B_FLAG] & ctl[B_IE];
    assign ev_out[c] = ev_q;
  end

  always_comb begin
    case (addr[1:0])
      A_CTL:   rdata = CW'(ctl_v[addr[2]]);
      A_LD:    rdata = ld_v[addr[2]];
      A_CNT:   rdata = cnt_v[addr[2]];
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pair)
      pwm_out <= 1'b0;
    else if (expire[0])
      pwm_out <= 1'b1;
    else if (expire[1])
      pwm_out <= 1'b0;
  end
endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk #(
  parameter int CW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          addr,
  input logic                we,
  input logic [1:0][7:0]     ctl_v,
  input logic [1:0][CW-1:0]  cnt_v,
  input logic [1:0][CW-1:0]  ld_v,
  input logic [1:0]          expire,
  input logic [1:0]          capt,
  input logic [1:0]          irq,
  input logic [1:0]          ev_out,
  input logic                pwm_out
);
  a_r3_load_now: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_v[0][3] |=> cnt_v[0] == $past(ld_v[0]));

  a_r3_ldnow_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_v[0][3] && !(we && addr == 3'd0) |=> !ctl_v[0][3]);

  a_r4_reload_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] && ctl_v[0][2] |=> cnt_v[0] == $past(ld_v[0]));

  a_r7_flag_set_ch0: assert property (@(posedge clk) disable iff (!rst_n)
    expire[0] |=> ctl_v[0][7]);

  a_r7_flag_set_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    expire[1] |=> ctl_v[1][7]);

  a_r6_event_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_out[0] |-> ctl_v[0][7]);

  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq[1] |-> ctl_v[1][4]);

  a_r9_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    capt[1] |=> ld_v[1] == $past(cnt_v[1]));

  a_r11_pwm_rise_on_period: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(expire[0]));
endmodule

bind dual_interval_timer dual_interval_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we),
  .ctl_v(ctl_v), .cnt_v(cnt_v), .ld_v(ld_v),
  .expire(expire), .capt(capt), .irq(irq), .ev_out(ev_out), .pwm_out(pwm_out)
);

// File: tb/dual_interval_timer_test.sv
module dual_interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  cap_in = '0;
  logic [1:0]  irq, ev_out;
  logic        pwm_out;

  int checks = 0;
  int fails = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  item_t it;

  dual_interval_timer #(.CW(32)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .irq(irq), .ev_out(ev_out), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0) begin
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = 32'(irq[0]);
        2: act = 32'(irq[1]);
        3: act = 32'(ev_out[0]);
        4: act = 32'(ev_out[1]);
        default: act = 32'(pwm_out);
      endcase
      check(it.tag, act, it.exp);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] v, input string tag);
    item_t x;
    addr = a;
    x.kind = 0; x.exp = v; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic pin(input int k, input logic [31:0] v, input string tag);
    item_t x;
    x.kind = k; x.exp = v; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
    #1;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int h;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(3'd0, 32'h0, "R1 ctl0"); pin(1, 0, "R1 irq0"); pin(2, 0, "R1 irq1");
    pin(3, 0, "R1 ev0"); pin(4, 0, "R1 ev1"); pin(5, 0, "R1 pwm"); settle();
    rd(3'd6, 32'h0, "R1 cnt1"); settle();
    rd(3'd5, 32'h0, "R1 ld1"); settle();

    // R5 R6 up-count rollover from preload, interrupt and event pulse
    wr(3'd1, 32'hFFFF_FFFD);
    wr(3'd0, 32'h19);
    tick(3);
    rd(3'd2, 32'hFFFF_FFFF, "R5 count before wrap"); pin(1, 0, "R6 irq0 before"); settle();
    tick(1);
    rd(3'd2, 32'h0, "R5 wrapped to zero"); pin(1, 1, "R6 irq0 raised"); pin(3, 1, "R6 ev0 pulse"); settle();
    tick(1);
    rd(3'd2, 32'h1, "R5 counts on"); pin(3, 0, "R6 ev0 one clock"); settle();
    wr(3'd0, 32'h80);
    pin(1, 0, "R7 irq0 cleared"); settle();

    // R3 R4 R7 down-count with reload, load-now timing, clear collision
    wr(3'd1, 32'd5);
    wr(3'd0, 32'h0F);
    tick(1);
    rd(3'd2, 32'd5, "R3 loaded next edge"); settle();
    tick(1);
    rd(3'd2, 32'd4, "R3 counting resumes"); settle();
    tick(4);
    rd(3'd2, 32'd0, "R4 reaches zero"); settle();
    tick(1);
    rd(3'd2, 32'd5, "R4 reload"); pin(3, 1, "R6 ev0 on reload"); settle();
    tick(1);
    rd(3'd0, 32'h87, "R4 flag set, load-now cleared"); settle();
    tick(4);
    wr(3'd0, 32'h87);
    rd(3'd0, 32'h87, "R7 set wins over clear"); settle();
    wr(3'd0, 32'h87);
    rd(3'd0, 32'h07, "R7 clear"); settle();
    wr(3'd0, 32'h80);

    // R10 R2 count writes ignored, map and channel isolation
    wr(3'd1, 32'hABC);
    wr(3'd0, 32'h08);
    tick(1);
    wr(3'd2, 32'h111);
    rd(3'd2, 32'hABC, "R10 count write ignored"); settle();
    rd(3'd3, 32'h0, "R2 unused code reads zero"); settle();

    // R8 capture with synchroniser latency
    wr(3'd5, 32'h1234);
    wr(3'd4, 32'h28);
    tick(1);
    wr(3'd5, 32'h0);
    rd(3'd5, 32'h0, "R2 ch1 load written"); settle();
    rd(3'd1, 32'hABC, "R2 ch0 load untouched"); settle();
    cap_in[1] = 1'b1;
    tick(2);
    rd(3'd5, 32'h0, "R8 not yet captured"); settle();
    tick(1);
    rd(3'd5, 32'h1234, "R8 captured"); settle();
    rd(3'd4, 32'hA0, "R8 flag on capture"); pin(2, 0, "R6 irq1 masked"); settle();
    cap_in[1] = 1'b0;
    tick(4);

    // R9 capture against bus write on the same edge
    wr(3'd5, 32'h777);
    wr(3'd4, 32'h28);
    tick(1);
    wr(3'd4, 32'hA0);
    cap_in[1] = 1'b1;
    tick(2);
    wr(3'd5, 32'h55);
    rd(3'd5, 32'h777, "R9 capture wins"); settle();
    rd(3'd4, 32'hA0, "R9 flag set"); settle();
    cap_in[1] = 1'b0;

    // R11 R12 paired PWM
    wr(3'd5, 32'd1);
    wr(3'd4, 32'h03);
    wr(3'd1, 32'd4);
    wr(3'd0, 32'h4F);
    tick(20);
    count_high(15, h);
    check("R11 high clocks over three periods", 32'(h), 32'd6);
    wr(3'd5, 32'd6);
    tick(20);
    count_high(15, h);
    check("R12 high time above period", 32'(h), 32'd15);
    wr(3'd5, 32'd4);
    tick(20);
    count_high(15, h);
    check("R12 high time equal to period", 32'(h), 32'd15);
    wr(3'd0, 32'h0F);
    tick(1);
    pin(5, 0, "R11 pair off drives low"); settle();

    tick(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule